// File: doc/BRIEF.md
# RV64 Register-Register Decode and Execute Unit

This block takes one 32-bit RISC-V instruction word and the two 64-bit source values already read for it. It produces the three register indices held in the word, the 64-bit result of the operation, a write strobe and a flag for encodings it does not handle. It has no internal state. Instruction word in to result out is pure logic, so a pipeline can place it in whichever stage suits its timing.

The unit handles the integer register-register group and the low-half 64-bit multiply. Decoding always looks at the whole pair of the 7-bit upper selector and the 3-bit minor selector. When a pair is not in the table, the unit raises the flag and gives a zero result. It never falls back to a near match. For the sake of the house layout, this write-up calls the two decode outcomes the "accepted" and "rejected" states. The unit holds no stored state, so no transitions exist between these outcomes.

Top module: `rrx_exec_unit`

## Requirements
- R1: The word is accepted only when bits [6:0] equal 0110011. For any other value `unsupported` is 1, `wr_en` is 0 and `result` is 0.
- R2: `rd_idx` is bits [11:7], `rs1_idx` is bits [19:15] and `rs2_idx` is bits [24:20]. Each index is 5 bits wide and is reported for every word.
- R3: With minor selector bits [14:12] = 000, the upper selector bits [31:25] pick the operation: 0000000 gives a+b, 0100000 gives a-b, and 0000001 gives the low 64 bits of a*b. All three wrap modulo 2^64, and no overflow is signalled.
- R4: Minor 001 with upper 0000000 is a logical left shift. Minor 101 with upper 0000000 is a logical right shift, and minor 101 with upper 0100000 is an arithmetic right shift. The shift distance is b[5:0], and all higher bits of b are ignored.
- R5: With upper 0000000, minor 100 gives a XOR b, minor 110 gives a OR b, and minor 111 gives a AND b.
- R6: Any other pair of upper and minor selectors sets `unsupported` to 1, `wr_en` to 0 and `result` to 0.
- R7: When `rd_idx` is 0, `wr_en` is 0. The result is still produced and `unsupported` is unaffected.
- R8: Word 0x00B50533 decodes as an add with rd=10, rs1=10, rs2=11. Word 0x40A60633 decodes as a subtract with rd=12, rs1=12, rs2=10.
- R9: For every accepted operation whose `rd_idx` is not 0, `wr_en` is 1 and `unsupported` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First source operand value |
| src_b | input | 64 | Second source operand value |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| result | output | 64 | Operation result, zero when rejected |
| wr_en | output | 1 | Result should be written to the destination |
| unsupported | output | 1 | Encoding is not handled |

## Verification
All outputs are due in the same clock cycle as the inputs that cause them, because no register lies on any path. The bench changes the inputs on a falling edge and reads the outputs 1 ns after the next rising edge. Every value has therefore had more than half a period to settle, and no check depends on the order of processes at an edge. The expected values come from arithmetic in the bench, covering all eight minor selectors, a spread of upper selector values, every opcode, every destination index and every shift distance up to 127.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

    localparam int unsigned IDX_W = 5;
    localparam logic [6:0]  OPC_REGREG = 7'b0110011;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_MUL,
        OP_SLL,
        OP_SRL,
        OP_SRA,
        OP_XOR,
        OP_OR,
        OP_AND
    } alu_op_e;

    // Bit order here is the instruction layout and must not change.
    typedef struct packed {
        logic [6:0]       upper;
        logic [IDX_W-1:0] src2;
        logic [IDX_W-1:0] src1;
        logic [2:0]       minor;
        logic [IDX_W-1:0] dst;
        logic [6:0]       opc;
    } iw_fields_t;

endpackage

// File: rtl/rrx_decode.sv
module rrx_decode
    import rrx_pkg::*;
(
    input  logic [6:0] opc,
    input  logic [6:0] upper,
    input  logic [2:0] minor,
    output alu_op_e    op,
    output logic       accepted
);

    always_comb begin
        op = OP_NONE;
        if (opc == OPC_REGREG) begin
            unique case ({upper, minor})
                {7'b0000000, 3'b000}: op = OP_ADD;
                {7'b0100000, 3'b000}: op = OP_SUB;
                {7'b0000001, 3'b000}: op = OP_MUL;
                {7'b0000000, 3'b001}: op = OP_SLL;
                {7'b0000000, 3'b101}: op = OP_SRL;
                {7'b0100000, 3'b101}: op = OP_SRA;
                {7'b0000000, 3'b100}: op = OP_XOR;
                {7'b0000000, 3'b110}: op = OP_OR;
                {7'b0000000, 3'b111}: op = OP_AND;
                default:              op = OP_NONE;
            endcase
        end
    end

    assign accepted = (op != OP_NONE);

endmodule

// File: rtl/rrx_alu.sv
module rrx_alu
    import rrx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int unsigned SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] prod_lo;

    assign shamt   = b[SHW-1:0];
    assign prod_lo = a * b;

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod_lo;
            OP_SLL:  y = a << shamt;
            OP_SRL:  y = a >> shamt;
            OP_SRA:  y = $unsigned($signed(a) >>> shamt);
            OP_XOR:  y = a ^ b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rrx_exec_unit.sv
module rrx_exec_unit
    import rrx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] rs1_idx,
    output logic [IDX_W-1:0] rs2_idx,
    output logic [XLEN-1:0]  result,
    output logic             wr_en,
    output logic             unsupported
);

    iw_fields_t      fld;
    alu_op_e         op;
    logic            accepted;
    logic [XLEN-1:0] alu_y;

    assign fld = instr;

    rrx_decode u_dec (
        .opc      (fld.opc),
        .upper    (fld.upper),
        .minor    (fld.minor),
        .op       (op),
        .accepted (accepted)
    );

    rrx_alu #(.XLEN(XLEN)) u_alu (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .y  (alu_y)
    );

    assign rd_idx      = fld.dst;
    assign rs1_idx     = fld.src1;
    assign rs2_idx     = fld.src2;
    assign result      = alu_y;
    assign unsupported = !accepted;
    assign wr_en       = accepted && (fld.dst != '0);

endmodule

// File: rtl/rrx_exec_checker.sv
module rrx_exec_checker #(
    parameter int unsigned XLEN = 64
) (
    input logic [31:0]     instr,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [4:0]      rd_idx,
    input logic [4:0]      rs1_idx,
    input logic [4:0]      rs2_idx,
    input logic [XLEN-1:0] result,
    input logic            wr_en,
    input logic            unsupported
);

    logic is_rr;
    assign is_rr = (instr[6:0] == 7'b0110011);

    always_comb begin
        if (!is_rr) begin
            assert_opcode_gate_R1: assert (unsupported && !wr_en && result == '0)
                else $error("R1: non register-register opcode not rejected");
        end
        assert_index_split_R2: assert (rd_idx == instr[11:7] && rs1_idx == instr[19:15]
                                       && rs2_idx == instr[24:20])
            else $error("R2: index fields misplaced");
        if (is_rr && instr[31:25] == 7'b0000000 && instr[14:12] == 3'b000) begin
            assert_add_wrap_R3: assert (result == src_a + src_b && !unsupported)
                else $error("R3: add result wrong");
        end
        if (is_rr && instr[31:25] == 7'b0000000 && instr[14:12] == 3'b111) begin
            assert_and_R5: assert (result == (src_a & src_b) && !unsupported)
                else $error("R5: and result wrong");
        end
        if (unsupported) begin
            assert_reject_quiet_R6: assert (!wr_en && result == '0)
                else $error("R6: rejected word still writes or drives result");
        end
        if (rd_idx == 5'd0) begin
            assert_zero_dest_R7: assert (!wr_en)
                else $error("R7: write strobe raised for index 0");
        end
        if (!unsupported && rd_idx != 5'd0) begin
            assert_write_strobe_R9: assert (wr_en)
                else $error("R9: accepted word without write strobe");
        end
    end

endmodule

bind rrx_exec_unit rrx_exec_checker #(.XLEN(XLEN)) u_chk (
    .instr       (instr),
    .src_a       (src_a),
    .src_b       (src_b),
    .rd_idx      (rd_idx),
    .rs1_idx     (rs1_idx),
    .rs2_idx     (rs2_idx),
    .result      (result),
    .wr_en       (wr_en),
    .unsupported (unsupported)
);

// File: tb/sim_rrx_exec_unit.sv
module sim_rrx_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [63:0] src_a = 64'h0;
    logic [63:0] src_b = 64'h0;
    logic [4:0]  rd_idx, rs1_idx, rs2_idx;
    logic [63:0] result;
    logic        wr_en, unsupported;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rrx_exec_unit #(.XLEN(64)) u0 (
        .instr       (instr),
        .src_a       (src_a),
        .src_b       (src_b),
        .rd_idx      (rd_idx),
        .rs1_idx     (rs1_idx),
        .rs2_idx     (rs2_idx),
        .result      (result),
        .wr_en       (wr_en),
        .unsupported (unsupported)
    );

    function automatic logic [31:0] mk(input logic [6:0] up, input logic [4:0] r2,
                                       input logic [4:0] r1, input logic [2:0] mi,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {up, r2, r1, mi, rd, opc};
    endfunction

    // {ok, value}: expected outcome from the requirement table
    function automatic logic [64:0] model(input logic [6:0] up, input logic [2:0] mi,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [5:0]  s;
        logic [63:0] p;
        s = b[5:0];
        p = a * b;
        if (up == 7'h00 && mi == 3'd0) return {1'b1, 64'(a + b)};
        if (up == 7'h20 && mi == 3'd0) return {1'b1, 64'(a - b)};
        if (up == 7'h01 && mi == 3'd0) return {1'b1, p};
        if (up == 7'h00 && mi == 3'd1) return {1'b1, 64'(a << s)};
        if (up == 7'h00 && mi == 3'd5) return {1'b1, 64'(a >> s)};
        if (up == 7'h20 && mi == 3'd5) return {1'b1, 64'($unsigned($signed(a) >>> s))};
        if (up == 7'h00 && mi == 3'd4) return {1'b1, 64'(a ^ b)};
        if (up == 7'h00 && mi == 3'd6) return {1'b1, 64'(a | b)};
        if (up == 7'h00 && mi == 3'd7) return {1'b1, 64'(a & b)};
        return {1'b0, 64'h0};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] iw, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        instr = iw;
        src_a = a;
        src_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [63:0] opa [8];
        logic [63:0] opb [8];
        logic [6:0]  ups [7];
        logic [64:0] m;
        string       tag;

        opa[0] = 64'hFFFF_FFFF_FFFF_FFFF; opb[0] = 64'h1;
        opa[1] = 64'h0;                   opb[1] = 64'h1;
        opa[2] = 64'h8000_0000_0000_0001; opb[2] = 64'h43;
        opa[3] = 64'h1234_5678_9ABC_DEF0; opb[3] = 64'hFFFF_0000_FFFF_0000;
        opa[4] = 64'h7FFF_FFFF_FFFF_FFFF; opb[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        opa[5] = 64'hDEAD_BEEF_0000_0005; opb[5] = 64'h3F;
        opa[6] = {$urandom, $urandom};    opb[6] = {$urandom, $urandom};
        opa[7] = {$urandom, $urandom};    opb[7] = {$urandom, $urandom};
        ups[0] = 7'h00; ups[1] = 7'h20; ups[2] = 7'h01; ups[3] = 7'h02;
        ups[4] = 7'h40; ups[5] = 7'h7F; ups[6] = 7'h21;

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: all-zero word has opcode 0 and must be rejected (R1)
        #1;
        check("R1", "idle unsupported", 64'(unsupported), 64'h1);
        check("R1", "idle wr_en", 64'(wr_en), 64'h0);
        check("R1", "idle result", result, 64'h0);

        // Known encodings (R8)
        apply(32'h00B5_0533, 64'd5, 64'd7);
        check("R8", "add rd", 64'(rd_idx), 64'd10);
        check("R8", "add rs1", 64'(rs1_idx), 64'd10);
        check("R8", "add rs2", 64'(rs2_idx), 64'd11);
        check("R8", "add result", result, 64'd12);
        check("R8", "add wr_en", 64'(wr_en), 64'h1);
        apply(32'h40A6_0633, 64'd20, 64'd3);
        check("R8", "sub rd", 64'(rd_idx), 64'd12);
        check("R8", "sub rs1", 64'(rs1_idx), 64'd12);
        check("R8", "sub rs2", 64'(rs2_idx), 64'd10);
        check("R8", "sub result", result, 64'd17);

        // Selector sweep (R3 R4 R5 R6 R9)
        for (int u = 0; u < 7; u++) begin
            for (int f = 0; f < 8; f++) begin
                for (int k = 0; k < 8; k++) begin
                    apply(mk(ups[u], 5'd3, 5'd4, 3'(f), 5'(k + 1), 7'h33), opa[k], opb[k]);
                    m = model(ups[u], 3'(f), opa[k], opb[k]);
                    if (!m[64]) tag = "R6";
                    else if (f == 0) tag = "R3";
                    else if (f == 1 || f == 5) tag = "R4";
                    else tag = "R5";
                    check(tag, "result", result, m[63:0]);
                    check(tag, "unsupported", 64'(unsupported), 64'(!m[64]));
                    check(m[64] ? "R9" : "R6", "wr_en", 64'(wr_en), 64'(m[64]));
                end
            end
        end

        // Shift distance sweep, upper bits of b ignored (R4)
        for (int s = 0; s < 128; s++) begin
            apply(mk(7'h00, 5'd1, 5'd2, 3'd1, 5'd9, 7'h33), 64'h8000_0000_0000_0001, 64'(s));
            check("R4", "sll", result, 64'h8000_0000_0000_0001 << (s % 64));
            apply(mk(7'h00, 5'd1, 5'd2, 3'd5, 5'd9, 7'h33), 64'h8000_0000_0000_0001, 64'(s));
            check("R4", "srl", result, 64'h8000_0000_0000_0001 >> (s % 64));
            apply(mk(7'h20, 5'd1, 5'd2, 3'd5, 5'd9, 7'h33), 64'h8000_0000_0000_0001, 64'(s));
            check("R4", "sra", result,
                  $unsigned($signed(64'h8000_0000_0000_0001) >>> (s % 64)));
        end

        // Opcode sweep (R1)
        for (int o = 0; o < 128; o++) begin
            apply(mk(7'h00, 5'd6, 5'd7, 3'd0, 5'd8, 7'(o)), 64'd100, 64'd23);
            if (o == 7'h33) begin
                check("R1", "accepted result", result, 64'd123);
                check("R1", "accepted flag", 64'(unsupported), 64'h0);
            end else begin
                check("R1", "rejected result", result, 64'h0);
                check("R1", "rejected flag", 64'(unsupported), 64'h1);
                check("R1", "rejected wr_en", 64'(wr_en), 64'h0);
            end
        end

        // Destination sweep (R2 R7 R9)
        for (int r = 0; r < 32; r++) begin
            apply(mk(7'h00, 5'(r ^ 5), 5'(31 - r), 3'd6, 5'(r), 7'h33),
                  64'hF0F0_0000_0000_0000, 64'(r));
            check("R2", "rd_idx", 64'(rd_idx), 64'(r));
            check("R2", "rs1_idx", 64'(rs1_idx), 64'(31 - r));
            check("R2", "rs2_idx", 64'(rs2_idx), 64'(r ^ 5));
            check(r == 0 ? "R7" : "R9", "wr_en", 64'(wr_en), 64'(r != 0));
            check("R7", "result kept", result, 64'hF0F0_0000_0000_0000 | 64'(r));
            check("R7", "unsupported", 64'(unsupported), 64'h0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule